// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is a bus-master engine on the transmit path. It walks a list of four-word descriptors in host memory and, for each descriptor it owns, streams that descriptor's data buffer to a transmit MAC as 32-bit words. Each word carries a frame-start marker, a frame-end marker, a byte-valid count and a per-frame flag that asks the MAC to append a CRC. The descriptors sit one after another at 16-byte steps. A chain flag can send the walk to an address held in the descriptor. An end-of-ring flag sends it back to the ring base, and this flag wins over the chain flag.

After reset the engine waits in `S_IDLE` until `poll_demand` is pulsed. It then runs through a fixed sequence of states. `S_OWN` reads word 0, which holds ownership and status. `S_CTRL` reads word 1, the control word. `S_BUF` reads word 2, the buffer pointer. `S_LINK` reads word 3, the chain pointer. `S_DATA` reads the buffer words. `S_WBACK` writes word 0 back with ownership cleared.

The transitions are as follows. `S_IDLE→S_OWN` happens on poll. `S_OWN→S_CTRL` happens when the descriptor is owned, and `S_OWN→S_IDLE` when it is not. `S_CTRL→S_BUF→S_LINK` follow in turn. `S_LINK→S_DATA` is taken for a non-empty buffer, and `S_LINK→S_WBACK` for an empty one. `S_DATA→S_WBACK` follows the last buffer word. `S_WBACK→S_OWN` moves to the next descriptor address. Each state leaves on the cycle its memory access completes.

Top module: `txdesc_walker`

## Requirements
- R1: After reset the engine makes no memory request until `poll_demand` is pulsed. Its first fetch then reads word 0 at `ring_base`.
- R2: When word 0 bit 31 is 0, the descriptor is not owned. The engine goes idle, and on the next `poll_demand` it fetches that same descriptor address again.
- R3: For an owned descriptor, the engine reads words 0, 1, 2 and 3, then reads the buffer. It then writes word 0 back with bit 31 cleared and every other bit unchanged.
- R4: Control bits 10:0 hold the buffer byte count n. The engine reads ceil(n/4) words from ascending addresses starting at word 2. Each word appears on `tx_data` with `tx_valid` one cycle after its read completes. `tx_bytes` is 4, except on the buffer's last word, where it is n mod 4 (or 4 when that is 0).
- R5: Control bit 29 marks a frame's first descriptor. `tx_sof` is raised on its first data word. Control bit 30 marks the last descriptor, and `tx_eof` is raised on its final data word.
- R6: `tx_crc_en` equals the inverse of control bit 26 of the frame's first descriptor. It holds that value on every word of the frame, and bit 26 of any other descriptor has no effect.
- R7: Control bit 31 of a frame's first descriptor sets `int_status[0]`. The bit is set one cycle after the write-back of that frame's last descriptor completes. Bit 31 on any other descriptor is ignored.
- R8: With control bits 24 and 25 both clear, the next descriptor address is the current address plus 16.
- R9: With control bit 24 set and bit 25 clear, the next descriptor address is word 3.
- R10: With control bit 25 set, the next descriptor address is `ring_base`, whatever bit 24 and word 3 hold.
- R11: A descriptor with bit 29 set that arrives while a frame is open ends the open frame. The engine pulses `tx_abort` for one cycle, with no data word alongside, sets `int_status[1]`, and starts the new frame.
- R12: `int_status` bits are sticky. Writing a 1 on `stat_clr` clears the matching bit and leaves the other bit alone.
- R13: `mem_req`, `mem_addr` and `mem_we` stay steady until `mem_rvalid`, and every address is word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | AW | Byte address of the first ring descriptor |
| poll_demand | input | 1 | Starts or resumes the walk from idle |
| stat_clr | input | 2 | Write-one-to-clear for `int_status` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data (descriptor word 0) |
| mem_rdata | input | 32 | Read data, valid with `mem_rvalid` |
| mem_rvalid | input | 1 | Access complete |
| tx_valid | output | 1 | Data word valid toward the MAC |
| tx_data | output | 32 | Data word |
| tx_sof | output | 1 | First word of a frame |
| tx_eof | output | 1 | Last word of a frame |
| tx_bytes | output | 3 | Valid bytes in this word, 1 to 4 |
| tx_crc_en | output | 1 | MAC should append a CRC to this frame |
| tx_abort | output | 1 | Open frame dropped |
| int_status | output | 2 | Bit 0 frame interrupt, bit 1 abort error |

## Verification
A data word appears on the MAC side exactly one cycle after its buffer read completes. The bench therefore checks, on every `tx_valid` sample, that the memory model completed a read at the previous sample. The frame interrupt and the abort error are registered one cycle after the write-back or control-word completion that causes them. Because of that, the bench compares `int_status`, the abort count and the expected-word queue only once the engine has made no request for many cycles. The next-address rules are checked by recording the first address fetched after each poll, and by comparing the whole memory image against the bench's own walk.

// File: rtl/txdw_pkg.sv
package txdw_pkg;

    localparam int OWN_BIT   = 31;
    localparam int IRQ_BIT   = 31;
    localparam int LAST_BIT  = 30;
    localparam int FIRST_BIT = 29;
    localparam int NOCRC_BIT = 26;
    localparam int REND_BIT  = 25;
    localparam int CHAIN_BIT = 24;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OWN,
        S_CTRL,
        S_BUF,
        S_LINK,
        S_DATA,
        S_WBACK
    } walk_state_t;

    typedef struct packed {
        logic irq_req;
        logic last_frag;
        logic first_frag;
        logic no_crc;
        logic ring_end;
        logic chained;
    } desc_ctrl_t;

endpackage

// File: rtl/txdw_ctrl_decode.sv
module txdw_ctrl_decode
    import txdw_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic [31:0]      ctrl_word,
    output desc_ctrl_t       ctl,
    output logic [CNT_W-1:0] word_cnt,
    output logic [2:0]       tail_bytes
);
    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] byte_cnt;
    logic [SUM_W-1:0] rounded;
    logic             unused_bits;

    assign byte_cnt = ctrl_word[CNT_W-1:0];
    assign rounded  = SUM_W'(byte_cnt) + SUM_W'(3);
    assign word_cnt = rounded[SUM_W-1:2];

    always_comb begin
        ctl.irq_req    = ctrl_word[IRQ_BIT];
        ctl.last_frag  = ctrl_word[LAST_BIT];
        ctl.first_frag = ctrl_word[FIRST_BIT];
        ctl.no_crc     = ctrl_word[NOCRC_BIT];
        ctl.ring_end   = ctrl_word[REND_BIT];
        ctl.chained    = ctrl_word[CHAIN_BIT];
        tail_bytes     = (byte_cnt[1:0] == 2'd0) ? 3'd4 : {1'b0, byte_cnt[1:0]};
    end

    assign unused_bits = ^{ctrl_word[28:27], ctrl_word[23:CNT_W], rounded[1:0]};
endmodule

// File: rtl/txdw_next_addr.sv
module txdw_next_addr #(
    parameter int AW         = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [AW-1:0] link_addr,
    input  logic [AW-1:0] ring_base,
    input  logic          chained,
    input  logic          ring_end,
    output logic [AW-1:0] next_addr
);
    always_comb begin
        if (ring_end)
            next_addr = ring_base;
        else if (chained)
            next_addr = link_addr;
        else
            next_addr = cur_addr + AW'(DESC_BYTES);
    end
endmodule

// File: rtl/txdesc_walker.sv
module txdesc_walker
    import txdw_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ring_base,
    input  logic          poll_demand,
    input  logic [1:0]    stat_clr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_rvalid,
    output logic          tx_valid,
    output logic [31:0]   tx_data,
    output logic          tx_sof,
    output logic          tx_eof,
    output logic [2:0]    tx_bytes,
    output logic          tx_crc_en,
    output logic          tx_abort,
    output logic [1:0]    int_status
);
    localparam int WORD_BYTES = 4;
    localparam int DESC_BYTES = 4 * WORD_BYTES;

    walk_state_t      state, state_nxt;
    logic [AW-1:0]    cur_addr, buf_ptr, link_addr, next_addr;
    logic [31:0]      own_word;
    desc_ctrl_t       ctl_d;
    logic [CNT_W-1:0] wcnt_d, words_left;
    logic [2:0]       tail_d, tail_q;
    logic             last_q, rend_q, chain_q;
    logic             based, frame_open, sof_pend, frm_crc, frm_irq;
    logic             last_word;

    txdw_ctrl_decode #(.CNT_W(CNT_W)) u_decode (
        .ctrl_word  (mem_rdata),
        .ctl        (ctl_d),
        .word_cnt   (wcnt_d),
        .tail_bytes (tail_d)
    );

    txdw_next_addr #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_next (
        .cur_addr  (cur_addr),
        .link_addr (link_addr),
        .ring_base (ring_base),
        .chained   (chain_q),
        .ring_end  (rend_q),
        .next_addr (next_addr)
    );

    assign last_word = (words_left == CNT_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:  if (poll_demand) state_nxt = S_OWN;
            S_OWN:   if (mem_rvalid) state_nxt = mem_rdata[OWN_BIT] ? S_CTRL : S_IDLE;
            S_CTRL:  if (mem_rvalid) state_nxt = S_BUF;
            S_BUF:   if (mem_rvalid) state_nxt = S_LINK;
            S_LINK:  if (mem_rvalid) state_nxt = (words_left == '0) ? S_WBACK : S_DATA;
            S_DATA:  if (mem_rvalid && last_word) state_nxt = S_WBACK;
            S_WBACK: if (mem_rvalid) state_nxt = S_OWN;
            default: state_nxt = S_IDLE;
        endcase
    end

    // memory port, decoded from the state
    always_comb begin
        mem_req   = (state != S_IDLE);
        mem_we    = (state == S_WBACK);
        mem_wdata = own_word & ~(32'd1 << OWN_BIT);
        unique case (state)
            S_CTRL:  mem_addr = cur_addr + AW'(1 * WORD_BYTES);
            S_BUF:   mem_addr = cur_addr + AW'(2 * WORD_BYTES);
            S_LINK:  mem_addr = cur_addr + AW'(3 * WORD_BYTES);
            S_DATA:  mem_addr = buf_ptr;
            default: mem_addr = cur_addr;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr   <= '0;
            buf_ptr    <= '0;
            link_addr  <= '0;
            own_word   <= '0;
            words_left <= '0;
            tail_q     <= 3'd4;
            last_q     <= 1'b0;
            rend_q     <= 1'b0;
            chain_q    <= 1'b0;
            based      <= 1'b0;
            frame_open <= 1'b0;
            sof_pend   <= 1'b0;
            frm_crc    <= 1'b0;
            frm_irq    <= 1'b0;
            tx_valid   <= 1'b0;
            tx_data    <= '0;
            tx_sof     <= 1'b0;
            tx_eof     <= 1'b0;
            tx_bytes   <= 3'd4;
            tx_crc_en  <= 1'b0;
            tx_abort   <= 1'b0;
            int_status <= 2'b00;
        end else begin
            tx_valid   <= 1'b0;
            tx_sof     <= 1'b0;
            tx_eof     <= 1'b0;
            tx_abort   <= 1'b0;
            int_status <= int_status & ~stat_clr;
            unique case (state)
                S_IDLE: begin
                    if (poll_demand && !based) begin
                        cur_addr <= ring_base;
                        based    <= 1'b1;
                    end
                end
                S_OWN: begin
                    if (mem_rvalid) own_word <= mem_rdata;
                end
                S_CTRL: begin
                    if (mem_rvalid) begin
                        words_left <= wcnt_d;
                        tail_q     <= tail_d;
                        last_q     <= ctl_d.last_frag;
                        rend_q     <= ctl_d.ring_end;
                        chain_q    <= ctl_d.chained;
                        if (ctl_d.first_frag) begin
                            if (frame_open) begin
                                tx_abort      <= 1'b1;
                                int_status[1] <= 1'b1;
                            end
                            frame_open <= 1'b1;
                            sof_pend   <= 1'b1;
                            frm_crc    <= ~ctl_d.no_crc;
                            frm_irq    <= ctl_d.irq_req;
                        end
                    end
                end
                S_BUF: begin
                    if (mem_rvalid) buf_ptr <= AW'(mem_rdata);
                end
                S_LINK: begin
                    if (mem_rvalid) link_addr <= AW'(mem_rdata);
                end
                S_DATA: begin
                    if (mem_rvalid) begin
                        tx_valid   <= 1'b1;
                        tx_data    <= mem_rdata;
                        tx_sof     <= sof_pend;
                        tx_eof     <= last_word && last_q;
                        tx_bytes   <= last_word ? tail_q : 3'd4;
                        tx_crc_en  <= frm_crc;
                        sof_pend   <= 1'b0;
                        buf_ptr    <= buf_ptr + AW'(WORD_BYTES);
                        words_left <= words_left - CNT_W'(1);
                    end
                end
                S_WBACK: begin
                    if (mem_rvalid) begin
                        if (last_q) begin
                            frame_open <= 1'b0;
                            if (frame_open && frm_irq) int_status[0] <= 1'b1;
                        end
                        cur_addr <= next_addr;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/txdw_checker.sv
module txdw_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    stat_clr,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_rvalid,
    input logic          tx_valid,
    input logic          tx_sof,
    input logic          tx_eof,
    input logic [2:0]    tx_bytes,
    input logic          tx_abort,
    input logic [1:0]    int_status
);
    logic unused_w;
    assign unused_w = ^mem_wdata[30:0];

    p_marker_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sof || tx_eof) |-> tx_valid);

    p_bytes_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_bytes >= 3'd1 && tx_bytes <= 3'd4));

    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_aligned_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    p_wb_own_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[31]);

    p_irq_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (int_status[0] && !stat_clr[0]) |=> int_status[0]);

    p_abort_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> int_status[1]);

    p_abort_no_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> !tx_valid);
endmodule

bind txdesc_walker txdw_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_clr   (stat_clr),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rvalid (mem_rvalid),
    .tx_valid   (tx_valid),
    .tx_sof     (tx_sof),
    .tx_eof     (tx_eof),
    .tx_bytes   (tx_bytes),
    .tx_abort   (tx_abort),
    .int_status (int_status)
);

// File: tb/txdesc_walker_tb.sv
module txdesc_walker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 1024;
    localparam logic [31:0] RING_BASE = 32'h100;
    localparam logic [31:0] BUF_BASE  = 32'h800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        poll_demand = 1'b0;
    logic [1:0]  stat_clr = 2'b00;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic        tx_valid, tx_sof, tx_eof, tx_crc_en, tx_abort;
    logic [31:0] tx_data;
    logic [2:0]  tx_bytes;
    logic [1:0]  int_status;

    txdesc_walker u_dut (
        .clk(clk), .rst_n(rst_n), .ring_base(RING_BASE), .poll_demand(poll_demand),
        .stat_clr(stat_clr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof),
        .tx_bytes(tx_bytes), .tx_crc_en(tx_crc_en), .tx_abort(tx_abort),
        .int_status(int_status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [31:0] data;
        logic        sof;
        logic        eof;
        logic [2:0]  bytes;
        logic        crc;
    } beat_t;

    logic [31:0] mem [MEM_WORDS];
    logic [31:0] sh  [MEM_WORDS];
    beat_t       exp_q[$];
    int          checks = 0, errors = 0, cycles = 0;
    int          aborts_seen = 0, m_aborts = 0;
    logic [1:0]  m_int = 2'b00;
    logic        m_open = 0, m_sofp = 0, m_crc = 0, m_irq = 0;
    logic [31:0] m_addr = RING_BASE;
    logic        gave_valid = 0, gave_we = 0, watch_first = 0;
    logic [31:0] first_req_addr = '0;
    int          delay = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory model and stream monitor, all at the falling edge
    always @(negedge clk) begin
        logic prev_read;
        beat_t got, want;
        cycles++;
        if (rst_n) begin
            prev_read = gave_valid && !gave_we;
            if (tx_valid) begin
                check(prev_read, "R4", "word not one cycle after read", 64'(tx_valid), 64'(1));
                got = {tx_data, tx_sof, tx_eof, tx_bytes, tx_crc_en};
                if (exp_q.size() == 0) begin
                    check(0, "R5", "unexpected data word", 64'(got), 64'(0));
                end else begin
                    want = exp_q.pop_front();
                    check(got == want, "R4 R5 R6", "data word {data,sof,eof,bytes,crc}",
                          64'(got), 64'(want));
                end
            end
            if (tx_abort) aborts_seen++;
            if (watch_first && mem_req) begin
                first_req_addr = mem_addr;
                watch_first    = 0;
            end
            if (gave_valid) begin
                mem_rvalid = 1'b0;
                gave_valid = 0;
            end else if (mem_req) begin
                if (delay > 0) delay--;
                else begin
                    if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
                    mem_rdata  = mem[mem_addr[11:2]];
                    mem_rvalid = 1'b1;
                    gave_valid = 1;
                    gave_we    = mem_we;
                    delay      = $urandom_range(0, 2);
                end
            end
        end
    end

    function automatic logic [31:0] mk_ctrl(input bit irq, input bit last, input bit first,
                                            input bit nocrc, input bit rend, input bit chain,
                                            input int cnt);
        return {irq, last, first, 2'b00, nocrc, rend, chain, 13'd0, 11'(cnt)};
    endfunction

    task automatic put_desc(input logic [31:0] a, input bit own, input logic [31:0] ctrl,
                            input logic [31:0] bufa, input logic [31:0] link);
        int n;
        mem[a[11:2]]     = {own, 15'd0, 16'($urandom)};
        mem[a[11:2] + 1] = ctrl;
        mem[a[11:2] + 2] = bufa;
        mem[a[11:2] + 3] = link;
        n = (int'(ctrl[10:0]) + 3) / 4;
        for (int i = 0; i < n; i++) mem[bufa[11:2] + 10'(i)] = $urandom;
    endtask

    // bench walk, computed from the requirements
    function automatic void model_walk(input logic [31:0] start);
        logic [31:0] a, w0, c, b, l;
        int n, nw;
        beat_t bt;
        a = start;
        for (int step = 0; step < 64; step++) begin
            w0 = sh[a[11:2]];
            if (!w0[31]) break;
            c = sh[a[11:2] + 1]; b = sh[a[11:2] + 2]; l = sh[a[11:2] + 3];
            if (c[29]) begin
                if (m_open) begin m_aborts++; m_int[1] = 1'b1; end
                m_open = 1; m_sofp = 1; m_crc = !c[26]; m_irq = c[31];
            end
            n  = int'(c[10:0]);
            nw = (n + 3) / 4;
            for (int i = 0; i < nw; i++) begin
                bt.data  = sh[b[11:2] + 10'(i)];
                bt.sof   = m_sofp;
                m_sofp   = 0;
                bt.eof   = (i == nw - 1) && c[30];
                bt.bytes = (i == nw - 1) ? ((n % 4 == 0) ? 3'd4 : 3'(n % 4)) : 3'd4;
                bt.crc   = m_crc;
                exp_q.push_back(bt);
            end
            sh[a[11:2]] = w0 & 32'h7fff_ffff;
            if (c[30]) begin
                if (m_open && m_irq) m_int[0] = 1'b1;
                m_open = 0;
            end
            a = c[25] ? RING_BASE : (c[24] ? l : a + 32'd16);
        end
        m_addr = a;
    endfunction

    task automatic run_walk(input string tag);
        logic [31:0] start;
        int quiet;
        start = m_addr;
        for (int i = 0; i < MEM_WORDS; i++) sh[i] = mem[i];
        model_walk(start);
        @(negedge clk);
        watch_first = 1;
        poll_demand = 1'b1;
        @(negedge clk);
        poll_demand = 1'b0;
        quiet = 0;
        while (quiet < 20) begin
            @(negedge clk);
            if (mem_req || gave_valid) quiet = 0; else quiet++;
        end
        check(first_req_addr == start, "R1 R2 R8 R9 R10", {tag, " first fetch after poll"},
              64'(first_req_addr), 64'(start));
        check(exp_q.size() == 0, "R4 R5", {tag, " words left unsent"}, 64'(exp_q.size()), 64'(0));
        check(int_status == m_int, "R7 R11", {tag, " int_status"}, 64'(int_status), 64'(m_int));
        check(aborts_seen == m_aborts, "R11", {tag, " abort count"}, 64'(aborts_seen), 64'(m_aborts));
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < MEM_WORDS; i++) if (mem[i] !== sh[i]) bad++;
            check(bad == 0, "R3", {tag, " memory image after write-back"}, 64'(bad), 64'(0));
        end
        exp_q.delete();
    endtask

    task automatic clear_status(input logic [1:0] bits);
        @(negedge clk);
        stat_clr = bits;
        @(negedge clk);
        stat_clr = 2'b00;
        m_int = m_int & ~bits;
    endtask

    initial begin
        int k;
        logic [31:0] a;
        bit rend;
        void'($urandom(32'd2024));
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_req && !tx_valid && int_status == 2'b00, "R1", "reset state",
              64'({mem_req, tx_valid, int_status}), 64'(0));
        repeat (10) begin
            @(negedge clk);
            check(!mem_req, "R1", "request without poll", 64'(mem_req), 64'(0));
        end

        // sequential singles from the ring base (R8 R5 R6 R7)
        put_desc(32'h100, 1, mk_ctrl(1,1,1,0,0,0,13), BUF_BASE + 32'h000, 32'h0);
        put_desc(32'h110, 1, mk_ctrl(0,1,1,1,0,0, 8), BUF_BASE + 32'h040, 32'h0);
        put_desc(32'h120, 1, mk_ctrl(0,1,1,0,0,0, 1), BUF_BASE + 32'h080, 32'h0);
        put_desc(32'h130, 0, 32'h0, BUF_BASE, 32'h0);
        run_walk("seq");
        clear_status(2'b11);

        // three fragments: options only from the first (R6 R7)
        put_desc(32'h130, 1, mk_ctrl(0,0,1,0,0,0, 6), BUF_BASE + 32'h000, 32'h0);
        put_desc(32'h140, 1, mk_ctrl(1,0,0,1,0,0, 8), BUF_BASE + 32'h040, 32'h0);
        put_desc(32'h150, 1, mk_ctrl(1,1,0,1,0,0, 3), BUF_BASE + 32'h080, 32'h0);
        put_desc(32'h160, 0, 32'h0, BUF_BASE, 32'h0);
        run_walk("frag_noirq");
        put_desc(32'h160, 1, mk_ctrl(1,0,1,1,0,0, 5), BUF_BASE + 32'h000, 32'h0);
        put_desc(32'h170, 1, mk_ctrl(0,1,0,0,0,0, 7), BUF_BASE + 32'h040, 32'h0);
        put_desc(32'h180, 0, 32'h0, BUF_BASE, 32'h0);
        run_walk("frag_irq");
        clear_status(2'b11);

        // chained walk (R9)
        put_desc(32'h180, 1, mk_ctrl(0,1,1,0,0,1, 4), BUF_BASE + 32'h000, 32'h400);
        put_desc(32'h400, 1, mk_ctrl(0,1,1,0,0,1,10), BUF_BASE + 32'h040, 32'h200);
        put_desc(32'h200, 1, mk_ctrl(0,1,1,0,0,0, 2), BUF_BASE + 32'h080, 32'h0);
        put_desc(32'h210, 0, 32'h0, BUF_BASE, 32'h0);
        run_walk("chain");

        // end of ring beats chain (R10); 0x500 owned but must not be visited
        put_desc(32'h210, 1, mk_ctrl(0,1,1,0,1,1, 9), BUF_BASE + 32'h000, 32'h500);
        put_desc(32'h500, 1, mk_ctrl(0,1,1,0,0,0, 4), BUF_BASE + 32'h040, 32'h0);
        run_walk("ring_end");
        check(m_addr == RING_BASE, "R10", "bench walk wrapped", 64'(m_addr), 64'(RING_BASE));

        // abort of an open frame (R11), then write-one-to-clear (R12)
        put_desc(32'h100, 1, mk_ctrl(0,0,1,0,0,0, 9), BUF_BASE + 32'h000, 32'h0);
        put_desc(32'h110, 1, mk_ctrl(1,1,1,0,0,0, 4), BUF_BASE + 32'h040, 32'h0);
        put_desc(32'h120, 0, 32'h0, BUF_BASE, 32'h0);
        run_walk("abort");
        check(int_status == 2'b11, "R11", "both status bits set", 64'(int_status), 64'(3));
        clear_status(2'b01);
        @(negedge clk);
        check(int_status == 2'b10, "R12", "clear bit 0 only", 64'(int_status), 64'(2));
        clear_status(2'b10);
        @(negedge clk);
        check(int_status == 2'b00, "R12", "clear bit 1", 64'(int_status), 64'(0));

        // constrained random rounds
        for (int r = 0; r < 10; r++) begin
            a = m_addr;
            k = $urandom_range(1, 5);
            rend = (a > 32'h700) || ($urandom_range(0, 2) == 0);
            for (int j = 0; j < k; j++) begin
                put_desc(a + 32'(16 * j), 1,
                         mk_ctrl($urandom_range(0,1), $urandom_range(0,1),
                                 $urandom_range(0,3) != 0, $urandom_range(0,1),
                                 rend && (j == k - 1), $urandom_range(0,3) == 0,
                                 $urandom_range(1, 40)),
                         BUF_BASE + 32'(64 * j), a + 32'(16 * (j + 1)));
            end
            if (rend) begin
                if (RING_BASE < a || RING_BASE >= a + 32'(16 * k))
                    put_desc(RING_BASE, 0, 32'h0, BUF_BASE, 32'h0);
            end else begin
                put_desc(a + 32'(16 * k), 0, 32'h0, BUF_BASE, 32'h0);
            end
            run_walk("random");
            clear_status(2'b11);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule